// File: doc/BRIEF.md
# USB Charging Port Classifier

This block works out which kind of USB port is supplying VBUS once a session becomes valid. It can tell a plain data port (standard downstream) from a data port that can also charge (charging downstream) and from a port that only charges (dedicated). The block drives a PHY that has battery-charging comparators. It does this through an abstract register command port that carries register writes and register reads. It runs three phases in order: data-contact detection, primary detection and secondary detection. The waits between phases are counted in ticks of a 1 µs timebase input.

While it works, the block asks the PHY to stay in non-driving mode. When it finishes, it reports the port kind and raises a done flag. It also sets a current budget in mA: the charger maximum for charging and dedicated ports, and one unit load for a standard port. For a standard port only, the host side may later replace that value with its configured or suspend figure. If the session is lost, any detection in progress stops and all results are cleared.

The command port uses valid/ready. `cmd_valid` rises with a complete command. Address, data and direction stay unchanged until `cmd_ready` is seen high on a clock edge, and only one command is ever outstanding. Read data is taken from `cmd_rdata` on the accepting edge. The one exception to holding a command is session loss: `cmd_valid` is then withdrawn on the next cycle, because the PHY is reset by the session logic in that case.

Top module: `chgdet_seq`

## Requirements
- R1: Out of reset there is no command, `port_type` is 0 (none), `det_done` and `phy_nondrive` are low and `budget` is 0.
- R2: When `sess_valid` is high and no result is held, `phy_nondrive` rises and stays high while any command is pending. The commands start with these writes: 0x3F to register 0x86, then 0x1F to 0x92, then 0x1F to 0x95. A wait of SETTLE_TICKS ticks follows, and then 0x10 is written to 0x85 to enable contact detection.
- R3: A command that is valid but not accepted keeps its address, data and direction on the next cycle, and no other command is issued until it is accepted.
- R4: Contact polling waits POLL_TICKS ticks and then reads register 0x87, where bit 1 set means contact. After contact, or after DCD_TRIES reads without it, the block writes 0x10 to 0x86. Every read goes to 0x87.
- R5: Primary detection writes 0x02 and then 0x01 to 0x85, waits DET_TICKS ticks and reads 0x87. If bit 0 is clear, the port is standard downstream (code 1) and the block goes straight to shutdown.
- R6: If the primary bit 0 is set, the block writes 0x08, 0x02 and 0x01 to 0x85, waits DET_TICKS ticks and reads 0x87. Bit 0 set gives a dedicated port (code 3); bit 0 clear gives a charging downstream port (code 2).
- R7: Shutdown writes 0x3F to 0x86, 0x1F to 0x92 and 0x1F to 0x95. On the next cycle `phy_nondrive` falls, and `det_done` rises together with a non-zero `port_type`.
- R8: When the result is given, `budget` becomes CHG_MAX_MA for codes 2 and 3 and UNIT_LOAD_MA for code 1.
- R9: `host_ma_valid` loads `host_ma` into `budget` only while `det_done` is high and the code is 1. In every other case it is ignored.
- R10: `budget` changes only to a value that differs from its present value. Each change comes with `budget_stb` high for exactly that one cycle, and `budget_stb` is never high without a change.
- R11: One cycle after `sess_valid` goes low, `cmd_valid`, `phy_nondrive` and `det_done` are low, `port_type` is 0 and `budget` is 0.
- R12: While `det_done` is high, no command is issued. A new detection starts only after the session drops and comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sess_valid | input | 1 | VBUS session valid |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| host_ma_valid | input | 1 | Host-side current value is present |
| host_ma | input | BW | Host-side allowed current in mA |
| cmd_valid | output | 1 | Register command offered |
| cmd_ready | input | 1 | Command accepted by the PHY port |
| cmd_write | output | 1 | 1 for a write, 0 for a read |
| cmd_addr | output | 8 | PHY register address |
| cmd_wdata | output | 8 | Write data (0 for reads) |
| cmd_rdata | input | 8 | Read data, taken on the accepting edge |
| port_type | output | 2 | 0 none, 1 standard, 2 charging downstream, 3 dedicated |
| det_done | output | 1 | Classification complete |
| budget | output | BW | Allowed current in mA |
| budget_stb | output | 1 | One-cycle pulse on each budget change |
| phy_nondrive | output | 1 | Request to keep the PHY in non-driving mode |

## Verification
Some properties are checked on every cycle. These are: commands are held under back-pressure, every read goes to the status register, `budget` moves only together with its strobe, the abort takes effect one cycle after session loss, the PHY is kept in non-driving mode whenever a command is offered, and a charging result carries the maximum budget.

Other behaviour can only be shown by the bench scenarios, run against a behavioural model under stalled acknowledges. This covers the exact order of register writes on each branch, the count of contact polls (cut short by contact, or run to the timeout), the three-way outcome of the comparator readings, the host override applied only for a standard port, and a restart after an abort part-way through.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

  typedef enum logic [1:0] {
    PT_NONE = 2'd0,
    PT_SDP  = 2'd1,
    PT_CDP  = 2'd2,
    PT_DCP  = 2'd3
  } port_t;

  typedef enum logic [2:0] {
    OP_WR,
    OP_RD_DCD,
    OP_RD_PRI,
    OP_RD_SEC,
    OP_WAIT,
    OP_END
  } op_t;

  typedef enum logic [1:0] {
    WT_SETTLE,
    WT_POLL,
    WT_DET
  } wsel_t;

  typedef struct packed {
    op_t        op;
    logic [7:0] addr;
    logic [7:0] data;
    wsel_t      wsel;
  } step_t;

  localparam int STEP_W = 5;

  // PHY register map used by the sequence
  localparam logic [7:0] REG_SET  = 8'h85;
  localparam logic [7:0] REG_CLR  = 8'h86;
  localparam logic [7:0] REG_STS  = 8'h87;
  localparam logic [7:0] REG_LAT  = 8'h92;
  localparam logic [7:0] REG_IEN  = 8'h95;

  localparam int STS_CMP_BIT = 0;
  localparam int STS_DCD_BIT = 1;

  // step indices that branches jump to
  localparam logic [STEP_W-1:0] ST_ON0    = 5'd0;
  localparam logic [STEP_W-1:0] ST_DCDW   = 5'd5;
  localparam logic [STEP_W-1:0] ST_DCDOFF = 5'd7;
  localparam logic [STEP_W-1:0] ST_SEC0   = 5'd12;
  localparam logic [STEP_W-1:0] ST_OFF0   = 5'd17;

endpackage

// File: rtl/chgdet_prog.sv
module chgdet_prog
  import chgdet_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output step_t             step_o
);

  function automatic step_t wr(input logic [7:0] a, input logic [7:0] d);
    step_t s;
    s.op = OP_WR; s.addr = a; s.data = d; s.wsel = WT_SETTLE;
    return s;
  endfunction

  function automatic step_t rd(input op_t o);
    step_t s;
    s.op = o; s.addr = REG_STS; s.data = 8'h00; s.wsel = WT_SETTLE;
    return s;
  endfunction

  function automatic step_t wt(input wsel_t w);
    step_t s;
    s.op = OP_WAIT; s.addr = 8'h00; s.data = 8'h00; s.wsel = w;
    return s;
  endfunction

  always_comb begin
    case (step_i)
      5'd0:    step_o = wr(REG_CLR, 8'h3F);
      5'd1:    step_o = wr(REG_LAT, 8'h1F);
      5'd2:    step_o = wr(REG_IEN, 8'h1F);
      5'd3:    step_o = wt(WT_SETTLE);
      5'd4:    step_o = wr(REG_SET, 8'h10);
      5'd5:    step_o = wt(WT_POLL);
      5'd6:    step_o = rd(OP_RD_DCD);
      5'd7:    step_o = wr(REG_CLR, 8'h10);
      5'd8:    step_o = wr(REG_SET, 8'h02);
      5'd9:    step_o = wr(REG_SET, 8'h01);
      5'd10:   step_o = wt(WT_DET);
      5'd11:   step_o = rd(OP_RD_PRI);
      5'd12:   step_o = wr(REG_SET, 8'h08);
      5'd13:   step_o = wr(REG_SET, 8'h02);
      5'd14:   step_o = wr(REG_SET, 8'h01);
      5'd15:   step_o = wt(WT_DET);
      5'd16:   step_o = rd(OP_RD_SEC);
      5'd17:   step_o = wr(REG_CLR, 8'h3F);
      5'd18:   step_o = wr(REG_LAT, 8'h1F);
      5'd19:   step_o = wr(REG_IEN, 8'h1F);
      default: begin
        step_o      = wt(WT_SETTLE);
        step_o.op   = OP_END;
      end
    endcase
  end

endmodule

// File: rtl/chgdet_timer.sv
module chgdet_timer #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/chgdet_budget.sv
module chgdet_budget #(
  parameter int BW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_v,
  input  logic [BW-1:0] req_val,
  output logic [BW-1:0] budget,
  output logic          stb
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget <= '0;
      stb    <= 1'b0;
    end else if (req_v && req_val != budget) begin
      budget <= req_val;
      stb    <= 1'b1;
    end else begin
      stb    <= 1'b0;
    end
  end

endmodule

// File: rtl/chgdet_seq.sv
module chgdet_seq
  import chgdet_pkg::*;
#(
  parameter int BW           = 12,
  parameter int UNIT_LOAD_MA = 100,
  parameter int CHG_MAX_MA   = 1500,
  parameter int SETTLE_TICKS = 100,
  parameter int POLL_TICKS   = 100000,
  parameter int DET_TICKS    = 40000,
  parameter int DCD_TRIES    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sess_valid,
  input  logic          tick_us,
  input  logic          host_ma_valid,
  input  logic [BW-1:0] host_ma,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_write,
  output logic [7:0]    cmd_addr,
  output logic [7:0]    cmd_wdata,
  input  logic [7:0]    cmd_rdata,
  output logic [1:0]    port_type,
  output logic          det_done,
  output logic [BW-1:0] budget,
  output logic          budget_stb,
  output logic          phy_nondrive
);

  localparam int MAX_A  = (SETTLE_TICKS > DET_TICKS) ? SETTLE_TICKS : DET_TICKS;
  localparam int MAX_T  = (MAX_A > POLL_TICKS) ? MAX_A : POLL_TICKS;
  localparam int CW     = $clog2(MAX_T + 1);
  localparam int RW     = $clog2(DCD_TRIES + 1);

  logic              run_q, done_q, arm_q;
  logic [STEP_W-1:0] step_q;
  logic [RW-1:0]     tries_q;
  port_t             cls_q, port_q;
  step_t             cur;

  logic              tmr_load, tmr_zero;
  logic [CW-1:0]     tmr_val;
  logic              req_v;
  logic [BW-1:0]     req_val;
  logic              is_cmd, last_try;
  logic              unused_rd;

  assign unused_rd = ^cmd_rdata[7:2];

  chgdet_prog u_prog (
    .step_i (step_q),
    .step_o (cur)
  );

  assign is_cmd       = run_q && (cur.op != OP_WAIT) && (cur.op != OP_END);
  assign cmd_valid    = is_cmd;
  assign cmd_write    = (cur.op == OP_WR);
  assign cmd_addr     = cur.addr;
  assign cmd_wdata    = cur.data;
  assign phy_nondrive = run_q;
  assign det_done     = done_q;
  assign port_type    = port_q;
  assign last_try     = (tries_q == RW'(DCD_TRIES - 1));

  always_comb begin
    case (cur.wsel)
      WT_POLL: tmr_val = CW'(POLL_TICKS);
      WT_DET:  tmr_val = CW'(DET_TICKS);
      default: tmr_val = CW'(SETTLE_TICKS);
    endcase
  end

  assign tmr_load = run_q && (cur.op == OP_WAIT) && !arm_q && sess_valid;

  chgdet_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick_us),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      arm_q   <= 1'b0;
      step_q  <= ST_ON0;
      tries_q <= '0;
      cls_q   <= PT_NONE;
      port_q  <= PT_NONE;
    end else if (!sess_valid) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      arm_q   <= 1'b0;
      step_q  <= ST_ON0;
      tries_q <= '0;
      cls_q   <= PT_NONE;
      port_q  <= PT_NONE;
    end else if (!run_q) begin
      if (!done_q) begin
        run_q   <= 1'b1;
        step_q  <= ST_ON0;
        tries_q <= '0;
        arm_q   <= 1'b0;
        cls_q   <= PT_NONE;
      end
    end else begin
      case (cur.op)
        OP_WR: if (cmd_ready) step_q <= step_q + 1'b1;
        OP_RD_DCD: if (cmd_ready) begin
          if (cmd_rdata[STS_DCD_BIT] || last_try) begin
            step_q <= ST_DCDOFF;
          end else begin
            tries_q <= tries_q + 1'b1;
            step_q  <= ST_DCDW;
          end
        end
        OP_RD_PRI: if (cmd_ready) begin
          if (cmd_rdata[STS_CMP_BIT]) begin
            step_q <= ST_SEC0;
          end else begin
            cls_q  <= PT_SDP;
            step_q <= ST_OFF0;
          end
        end
        OP_RD_SEC: if (cmd_ready) begin
          cls_q  <= cmd_rdata[STS_CMP_BIT] ? PT_DCP : PT_CDP;
          step_q <= ST_OFF0;
        end
        OP_WAIT: begin
          if (!arm_q) begin
            arm_q <= 1'b1;
          end else if (tmr_zero) begin
            arm_q  <= 1'b0;
            step_q <= step_q + 1'b1;
          end
        end
        default: begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          port_q <= cls_q;
        end
      endcase
    end
  end

  always_comb begin
    req_v   = 1'b0;
    req_val = '0;
    if (!sess_valid) begin
      req_v = 1'b1;
    end else if (run_q && cur.op == OP_END) begin
      req_v   = 1'b1;
      req_val = (cls_q == PT_SDP) ? BW'(UNIT_LOAD_MA) : BW'(CHG_MAX_MA);
    end else if (done_q && port_q == PT_SDP && host_ma_valid) begin
      req_v   = 1'b1;
      req_val = host_ma;
    end
  end

  chgdet_budget #(.BW(BW)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_v   (req_v),
    .req_val (req_val),
    .budget  (budget),
    .stb     (budget_stb)
  );

endmodule

// File: rtl/chgdet_seq_chk.sv
module chgdet_seq_chk #(
  parameter int BW         = 12,
  parameter int CHG_MAX_MA = 1500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sess_valid,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_write,
  input logic [7:0]    cmd_addr,
  input logic [7:0]    cmd_wdata,
  input logic [1:0]    port_type,
  input logic          det_done,
  input logic [BW-1:0] budget,
  input logic          budget_stb,
  input logic          phy_nondrive
);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && sess_valid |=>
      cmd_valid && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_write));

  p_read_sts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write |-> cmd_addr == 8'h87);

  p_cmd_nondrive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> phy_nondrive);

  p_done_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_done) |-> port_type != 2'd0 && !phy_nondrive);

  p_max_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
    det_done && port_type[1] |-> budget == BW'(CHG_MAX_MA));

  p_stb_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    budget_stb |-> budget != $past(budget));

  p_quiet_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !budget_stb |-> budget == $past(budget));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_valid |=> !cmd_valid && !phy_nondrive && !det_done &&
                    port_type == 2'd0 && budget == '0);

  p_idle_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |-> !cmd_valid);

endmodule

bind chgdet_seq chgdet_seq_chk #(.BW(BW), .CHG_MAX_MA(CHG_MAX_MA)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sess_valid   (sess_valid),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_write    (cmd_write),
  .cmd_addr     (cmd_addr),
  .cmd_wdata    (cmd_wdata),
  .port_type    (port_type),
  .det_done     (det_done),
  .budget       (budget),
  .budget_stb   (budget_stb),
  .phy_nondrive (phy_nondrive)
);

// File: tb/chgdet_seq_tb_top.sv
module chgdet_seq_tb_top;

  localparam int BW = 12, UNIT = 100, CMAX = 1500;
  localparam int ST = 3, PO = 12, DT = 6, TRIES = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sess_valid = 1'b0, tick_us = 1'b0;
  logic host_ma_valid = 1'b0;
  logic [BW-1:0] host_ma = '0;
  logic cmd_valid, cmd_ready = 1'b0, cmd_write;
  logic [7:0] cmd_addr, cmd_wdata, cmd_rdata = 8'h00;
  logic [1:0] port_type;
  logic det_done, budget_stb, phy_nondrive;
  logic [BW-1:0] budget;

  chgdet_seq #(.BW(BW), .UNIT_LOAD_MA(UNIT), .CHG_MAX_MA(CMAX),
    .SETTLE_TICKS(ST), .POLL_TICKS(PO), .DET_TICKS(DT), .DCD_TRIES(TRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .sess_valid(sess_valid), .tick_us(tick_us),
    .host_ma_valid(host_ma_valid), .host_ma(host_ma),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .port_type(port_type), .det_done(det_done), .budget(budget),
    .budget_stb(budget_stb), .phy_nondrive(phy_nondrive));

  int errors = 0, checks = 0, cyc = 0, rd87 = 0, busy_cmds = 0;
  int contact_at = 1, prim_v = 0, sec_v = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: a queue of pending operations
  typedef struct { int kind; int addr; int data; int n; } mop_t; // kind 0 wr,1 dcd rd,2 pri rd,3 sec rd,4 wait,5 finish
  mop_t q[$];
  int m_run = 0, m_done = 0, m_arm = 0, m_cnt = 0, m_tries = 0, m_cls = 0;
  int m_port = 0, m_budget = 0, m_stb = 0, m_polls = 0, m_sec = 0;

  task automatic pw(input int a, input int d); mop_t o; o.kind = 0; o.addr = a; o.data = d; o.n = 0; q.push_back(o); endtask
  task automatic pk(input int k, input int n); mop_t o; o.kind = k; o.addr = (k >= 1 && k <= 3) ? 'h87 : 0; o.data = 0; o.n = n; q.push_back(o); endtask
  task automatic push_off(); pw('h86, 'h3F); pw('h92, 'h1F); pw('h95, 'h1F); pk(5, 0); endtask

  function automatic bit m_cmdv();
    return m_run != 0 && q.size() > 0 && q[0].kind <= 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_run = 0; m_done = 0; m_arm = 0; m_cnt = 0; m_port = 0;
      m_budget = 0; m_stb = 0; m_polls = 0; m_sec = 0; m_cls = 0;
    end else begin
      int old_done, old_port, rqv, rqval, ld, ldn;
      mop_t op;
      old_done = m_done; old_port = m_port; rqv = 0; rqval = 0; ld = 0; ldn = 0;
      if (!sess_valid) begin
        q.delete(); m_run = 0; m_done = 0; m_arm = 0; m_port = 0; m_cls = 0;
        rqv = 1; rqval = 0;
      end else if (m_run == 0) begin
        if (m_done == 0) begin
          m_run = 1; m_tries = 0; m_arm = 0; m_polls = 0; m_sec = 0; m_cls = 0;
          pw('h86, 'h3F); pw('h92, 'h1F); pw('h95, 'h1F); pk(4, ST);
          pw('h85, 'h10); pk(4, PO); pk(1, 0);
        end
      end else begin
        op = q[0];
        case (op.kind)
          0: if (cmd_ready) void'(q.pop_front());
          1: if (cmd_ready) begin
            void'(q.pop_front()); m_tries++; m_polls++;
            if (cmd_rdata[1] || m_tries == TRIES) begin
              pw('h86, 'h10); pw('h85, 'h02); pw('h85, 'h01); pk(4, DT); pk(2, 0);
            end else begin
              pk(4, PO); pk(1, 0);
            end
          end
          2: if (cmd_ready) begin
            void'(q.pop_front());
            if (cmd_rdata[0]) begin
              m_sec = 1; pw('h85, 'h08); pw('h85, 'h02); pw('h85, 'h01); pk(4, DT); pk(3, 0);
            end else begin
              m_cls = 1; push_off();
            end
          end
          3: if (cmd_ready) begin
            void'(q.pop_front()); m_cls = cmd_rdata[0] ? 3 : 2; push_off();
          end
          4: if (m_arm == 0) begin m_arm = 1; ld = 1; ldn = op.n; end
             else if (m_cnt == 0) begin m_arm = 0; void'(q.pop_front()); end
          default: begin
            void'(q.pop_front()); m_run = 0; m_done = 1; m_port = m_cls;
            rqv = 1; rqval = (m_cls == 1) ? UNIT : CMAX;
          end
        endcase
      end
      if (sess_valid && old_done != 0 && old_port == 1 && host_ma_valid) begin
        rqv = 1; rqval = int'(host_ma);
      end
      if (ld != 0) m_cnt = ldn;
      else if (tick_us && m_cnt != 0) m_cnt--;
      m_stb = 0;
      if (rqv != 0 && rqval != m_budget) begin m_budget = rqval; m_stb = 1; end
      if (cmd_valid && cmd_ready && !cmd_write && cmd_addr == 8'h87) rd87++;
    end
  end

  // compare against the model, then drive responder inputs
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(cmd_valid == m_cmdv(), "R3", "cmd_valid", int'(cmd_valid), int'(m_cmdv()));
      if (m_cmdv()) begin
        chk(cmd_write == (q[0].kind == 0), "R2", "cmd_write", int'(cmd_write), int'(q[0].kind == 0));
        chk(int'(cmd_addr) == q[0].addr, "R2", "cmd_addr", int'(cmd_addr), q[0].addr);
        chk(int'(cmd_wdata) == q[0].data, "R2", "cmd_wdata", int'(cmd_wdata), q[0].data);
      end
      chk(int'(phy_nondrive) == m_run, "R7", "phy_nondrive", int'(phy_nondrive), m_run);
      chk(int'(det_done) == m_done, "R7", "det_done", int'(det_done), m_done);
      chk(int'(port_type) == m_port, "R6", "port_type", int'(port_type), m_port);
      chk(int'(budget) == m_budget, "R8", "budget", int'(budget), m_budget);
      chk(int'(budget_stb) == m_stb, "R10", "budget_stb", int'(budget_stb), m_stb);
      if (det_done && cmd_valid) busy_cmds++;
    end
    cmd_ready <= (cyc % 3) != 1;
    tick_us   <= cyc[0];
    cmd_rdata <= {6'b0, (m_polls + 1 >= contact_at), (m_sec != 0) ? prim_sec(1) : prim_sec(0)};
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic prim_sec(input int s);
    return (s != 0) ? logic'(sec_v != 0) : logic'(prim_v != 0);
  endfunction

  task automatic run_det(input int c_at, input int p, input int s, input int exp_port,
                         input int exp_reads, input int exp_budget, input string req);
    bit seen;
    seen = 0;
    contact_at = c_at; prim_v = p; sec_v = s; rd87 = 0;
    @(negedge clk); sess_valid = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (det_done) begin seen = 1; break; end
    end
    chk(seen, req, "det_done reached", int'(seen), 1);
    chk(int'(port_type) == exp_port, req, "port_type", int'(port_type), exp_port);
    chk(rd87 == exp_reads, "R4", "status reads", rd87, exp_reads);
    chk(int'(budget) == exp_budget, "R8", "budget", int'(budget), exp_budget);
  endtask

  task automatic drop_sess();
    sess_valid = 1'b0;
    @(negedge clk);
    chk(!cmd_valid && !phy_nondrive && !det_done, "R11", "cleared flags",
        int'({cmd_valid, phy_nondrive, det_done}), 0);
    chk(port_type == 2'd0, "R11", "port_type", int'(port_type), 0);
    chk(budget == '0, "R11", "budget", int'(budget), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !det_done && !phy_nondrive, "R1", "idle flags in reset",
        int'({cmd_valid, det_done, phy_nondrive}), 0);
    chk(budget == '0 && port_type == 2'd0, "R1", "budget/port in reset", int'(budget), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cmd_valid && budget == '0, "R1", "idle after reset", int'(cmd_valid), 0);

    // standard port, contact on second poll
    run_det(2, 0, 0, 1, 3, UNIT, "R5");
    busy_cmds = 0;
    repeat (20) @(negedge clk);
    chk(busy_cmds == 0 && det_done, "R12", "no commands after done", busy_cmds, 0);
    host_ma = 12'd500; host_ma_valid = 1'b1;
    @(negedge clk); host_ma_valid = 1'b0;
    chk(budget == 12'd500 && budget_stb, "R9", "host override", int'(budget), 500);
    host_ma_valid = 1'b1;
    @(negedge clk); host_ma_valid = 1'b0;
    chk(!budget_stb && budget == 12'd500, "R10", "same value no strobe", int'(budget_stb), 0);
    drop_sess();

    // charging downstream port, contact at once
    run_det(1, 1, 0, 2, 3, CMAX, "R6");
    host_ma = 12'd700; host_ma_valid = 1'b1;
    @(negedge clk); host_ma_valid = 1'b0;
    @(negedge clk);
    chk(budget == BW'(CMAX), "R9", "override ignored for CDP", int'(budget), CMAX);
    drop_sess();

    // dedicated port, contact never seen: timeout after all polls
    run_det(99, 1, 1, 3, TRIES + 2, CMAX, "R6");
    drop_sess();

    // abort part-way through contact polling, then restart
    contact_at = 99; prim_v = 0;
    sess_valid = 1'b1;
    repeat (30) @(negedge clk);
    chk(phy_nondrive, "R2", "non-driving during detection", int'(phy_nondrive), 1);
    drop_sess();
    repeat (3) @(negedge clk);
    chk(!phy_nondrive && !cmd_valid, "R11", "stays idle without session", int'(phy_nondrive), 0);
    run_det(1, 0, 0, 1, 2, UNIT, "R5");
    drop_sess();

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule